// File: doc/BRIEF.md
# Edge Interrupt and Wake Unit

This block watches a bank of already-synchronized pin levels and turns level transitions into sticky pending events. Each pin has four enable bits: one for rising edges and one for falling edges that feed the normal interrupt path, plus a second rising/falling pair that feeds a separate wake-up path. Triggering is edge-only; there is no level-sensitive mode.

Pending interrupt bits form a status word. Their OR drives a single interrupt line to the parent controller, and a priority encoder reports the lowest-numbered pending pin so that software can service pins from the bottom up. Wake events are held in their own sticky bank, and the OR of that bank is the wake request. Software acknowledges both kinds of event by writing ones to a clear port. A register interface writes the four enable words and reads back the enables and both pending banks.

Top module: `eiw_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the pending status is zero and `irq_o`, `wake_o` and `low_valid_o` are low. Read select 0 (interrupt rising enable), 2 (wake rising enable) and 3 (wake falling enable) read zero. Read select 1 (interrupt falling enable) reads all ones.
- R2: A rising transition on pin k with interrupt rising enable bit k set makes `status_o[k]` 1 at the clock edge that first samples the new level. The bit stays set after the pin returns low. A falling transition with only the rising enable set leaves `status_o[k]` at 0.
- R3: With both interrupt enables set for a pin, each transition in either direction sets its status bit.
- R4: With the enables at their reset values, a rising transition sets no status bit and a falling transition does set one.
- R5: A transition matching a wake enable sets the matching bit of the wake pending bank, which is read at select 5. The normal enables have no influence on this. `wake_o` is 1 one cycle after any wake pending bit is set. A wake-only event leaves `status_o` unchanged.
- R6: A write to select 6 (clear) clears every status bit and every wake pending bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R7: If a clear and a new enabled edge hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_o` equals the OR of `status_o` delayed by one cycle.
- R9: One cycle after the status changes, `low_idx_o` gives the index of the least significant set status bit and `low_valid_o` is 1. When the status is zero, `low_valid_o` is 0.
- R10: Writing an enable register while a pin holds a steady level creates no pending bit. Only a later transition counts.
- R11: Writes to select 4 (status) and select 5 (wake pending) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | N | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0..3 enables, 6 clear |
| wr_data_i | input | N | Write data, one bit per pin |
| rd_sel_i | input | 3 | Read select: 0..3 enables, 4 status, 5 wake pending |
| rd_data_o | output | N | Registered read data, valid one cycle after the select |
| status_o | output | N | Pending interrupt bits |
| irq_o | output | 1 | Combined interrupt to the parent controller |
| wake_o | output | 1 | Combined wake request |
| low_idx_o | output | IDXW | Index of the lowest pending pin |
| low_valid_o | output | 1 | A pending pin exists |

## Verification
On every cycle the assertions check several properties. A status bit can only rise because of an enabled edge in the previous cycle, and can only fall because of a clear write. A set always wins over a clear. The interrupt line, the wake request and the valid flag track the pending banks with a one-cycle lag. The bench scenarios are needed for the rest. They cover the reset values of the enables and the per-direction selectivity, including the falling-only default. They check that wake and normal paths stay independent, that partial clears and ignored writes behave, and that the lowest-index encoder gives correct values. They also show that enabling a pin held at a steady level records nothing.

// File: rtl/eiw_pkg.sv
package eiw_pkg;
  typedef enum logic [2:0] {
    SEL_IRQ_RISE  = 3'd0,
    SEL_IRQ_FALL  = 3'd1,
    SEL_WAKE_RISE = 3'd2,
    SEL_WAKE_FALL = 3'd3,
    SEL_STATUS    = 3'd4,
    SEL_WAKE_STAT = 3'd5,
    SEL_CLEAR     = 3'd6
  } reg_sel_e;

  localparam int NUM_EN = 4;
endpackage

// File: rtl/eiw_enable_regs.sv
module eiw_enable_regs #(
  parameter int N = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [N-1:0]                  wr_data,
  output logic [eiw_pkg::NUM_EN-1:0][N-1:0] en_o
);
  import eiw_pkg::*;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    // Only the interrupt falling enable comes out of reset set.
    localparam logic [N-1:0] RST_VAL = (g == int'(SEL_IRQ_FALL)) ? {N{1'b1}} : {N{1'b0}};
    logic [N-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else if (wr_en && wr_sel == 3'(g)) q <= wr_data;
    end
    assign en_o[g] = q;
  end
endmodule

// File: rtl/eiw_edge_detect.sv
module eiw_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  // Tracks the pin during reset too, so no edge is seen on release.
  always_ff @(posedge clk) begin
    lvl_q <= pin_i;
  end

  assign rise_o = rst ? '0 :  pin_i & ~lvl_q;
  assign fall_o = rst ? '0 : ~pin_i &  lvl_q;
endmodule

// File: rtl/eiw_sticky.sv
module eiw_sticky #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/eiw_lowest.sv
module eiw_lowest #(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    vec_i,
  output logic [IDXW-1:0] idx_o,
  output logic            valid_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDXW'(i);
    end
  end

  assign valid_o = |vec_i;
endmodule

// File: rtl/eiw_unit.sv
module eiw_unit #(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    pin_lvl_i,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_sel_i,
  input  logic [N-1:0]    wr_data_i,
  input  logic [2:0]      rd_sel_i,
  output logic [N-1:0]    rd_data_o,
  output logic [N-1:0]    status_o,
  output logic            irq_o,
  output logic            wake_o,
  output logic [IDXW-1:0] low_idx_o,
  output logic            low_valid_o
);
  import eiw_pkg::*;

  logic [NUM_EN-1:0][N-1:0] en;
  logic [N-1:0] rise, fall, irq_set, wake_set, clr_vec, irq_pend, wake_pend;
  logic [IDXW-1:0] low_idx_c;
  logic            low_valid_c;

  eiw_enable_regs #(.N(N)) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
    .wr_data(wr_data_i), .en_o(en)
  );

  eiw_edge_detect #(.N(N)) u_edge (
    .clk(clk), .rst(rst), .pin_i(pin_lvl_i), .rise_o(rise), .fall_o(fall)
  );

  assign irq_set  = (rise & en[SEL_IRQ_RISE])  | (fall & en[SEL_IRQ_FALL]);
  assign wake_set = (rise & en[SEL_WAKE_RISE]) | (fall & en[SEL_WAKE_FALL]);
  assign clr_vec  = (wr_en_i && wr_sel_i == SEL_CLEAR) ? wr_data_i : '0;

  eiw_sticky #(.N(N)) u_irq_pend (
    .clk(clk), .rst(rst), .set_i(irq_set), .clr_i(clr_vec), .pend_o(irq_pend)
  );

  eiw_sticky #(.N(N)) u_wake_pend (
    .clk(clk), .rst(rst), .set_i(wake_set), .clr_i(clr_vec), .pend_o(wake_pend)
  );

  eiw_lowest #(.N(N), .IDXW(IDXW)) u_low (
    .vec_i(irq_pend), .idx_o(low_idx_c), .valid_o(low_valid_c)
  );

  assign status_o = irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      wake_o      <= 1'b0;
      low_idx_o   <= '0;
      low_valid_o <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      irq_o       <= |irq_pend;
      wake_o      <= |wake_pend;
      low_idx_o   <= low_idx_c;
      low_valid_o <= low_valid_c;
      case (rd_sel_i)
        SEL_IRQ_RISE, SEL_IRQ_FALL,
        SEL_WAKE_RISE, SEL_WAKE_FALL: rd_data_o <= en[rd_sel_i[1:0]];
        SEL_STATUS:                   rd_data_o <= irq_pend;
        SEL_WAKE_STAT:                rd_data_o <= wake_pend;
        default:                      rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/eiw_unit_chk.sv
module eiw_unit_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] c_status,
  input logic [N-1:0] c_wake_pend,
  input logic [N-1:0] c_irq_set,
  input logic [N-1:0] c_clr,
  input logic         c_irq,
  input logic         c_wake,
  input logic         c_valid
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  status_rise_from_edge_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ((c_status & ~$past(c_status) & ~$past(c_irq_set)) == '0));

  // R6
  status_fall_from_clear_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(c_status) & ~c_status & ~$past(c_clr)) == '0));

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(c_irq_set) & ~c_status) == '0));

  // R8
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (c_irq == (|$past(c_status))));

  // R5
  wake_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (c_wake == (|$past(c_wake_pend))));

  // R9
  valid_tracks_status_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (c_valid == (|$past(c_status))));
endmodule

bind eiw_unit eiw_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .c_status(status_o), .c_wake_pend(wake_pend),
  .c_irq_set(irq_set), .c_clr(clr_vec), .c_irq(irq_o), .c_wake(wake_o),
  .c_valid(low_valid_o)
);

// File: tb/eiw_unit_test.sv
module eiw_unit_test;
  localparam int N = 32;
  localparam int IDXW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [N-1:0] rd_data, status;
  logic irq, wake, low_valid;
  logic [IDXW-1:0] low_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eiw_unit #(.N(N), .IDXW(IDXW)) uut (
    .clk(clk), .rst(rst), .pin_lvl_i(pins), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .status_o(status), .irq_o(irq), .wake_o(wake), .low_idx_o(low_idx),
    .low_valid_o(low_valid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: act %0d cycles exp < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [N-1:0] d);
    rd_sel = sel;
    tick();
    d = rd_data;
  endtask

  task automatic setup(input logic [N-1:0] ir, input logic [N-1:0] ifl,
                       input logic [N-1:0] wrs, input logic [N-1:0] wfl);
    wr(3'd0, ir); wr(3'd1, ifl); wr(3'd2, wrs); wr(3'd3, wfl);
    wr(3'd6, '1);
    tick();
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check("R1 status", status, '0);
    check("R1 irq", N'(irq), '0);
    check("R1 wake", N'(wake), '0);
    check("R1 valid", N'(low_valid), '0);
    rd(3'd0, d); check("R1 irq rise en", d, '0);
    rd(3'd1, d); check("R1 irq fall en", d, '1);
    rd(3'd2, d); check("R1 wake rise en", d, '0);
    rd(3'd3, d); check("R1 wake fall en", d, '0);
  endtask

  task automatic t_default_fall();
    pins[3] = 1'b1; tick();
    check("R4 rise ignored", status, '0);
    pins[3] = 1'b0; tick();
    check("R4 fall sets", status, 32'h8);
    check("R8 irq lags", N'(irq), '0);
    tick();
    check("R8 irq high", N'(irq), 1);
    check("R9 idx 3", N'(low_idx), 3);
    wr(3'd6, 32'h8);
    check("R6 clear", status, '0);
    tick();
    check("R8 irq low", N'(irq), '0);
    check("R9 valid low", N'(low_valid), '0);
  endtask

  task automatic t_rise_only();
    setup(32'h80, '0, '0, '0);
    pins[7] = 1'b1; tick();
    check("R2 rise sets", status, 32'h80);
    pins[7] = 1'b0; tick();
    check("R2 sticky", status, 32'h80);
    wr(3'd6, '1);
    pins[7] = 1'b1; tick();
    pins[7] = 1'b0; wr(3'd6, 32'h80); tick();
    check("R2 fall ignored", status, '0);
  endtask

  task automatic t_both();
    setup(32'h4, 32'h4, '0, '0);
    pins[2] = 1'b1; tick();
    check("R3 rise", status, 32'h4);
    wr(3'd6, 32'h4);
    pins[2] = 1'b0; tick();
    check("R3 fall", status, 32'h4);
  endtask

  task automatic t_wake();
    logic [N-1:0] d;
    setup('0, '0, 32'h1000, '0);
    pins[12] = 1'b1; tick();
    check("R5 status untouched", status, '0);
    tick();
    check("R5 wake high", N'(wake), 1);
    rd(3'd5, d); check("R5 wake pend", d, 32'h1000);
    wr(3'd6, 32'h1000); tick();
    check("R5 wake cleared", N'(wake), '0);
    pins[12] = 1'b0; tick();
  endtask

  task automatic t_clear_partial();
    setup(32'h50, '0, '0, '0);
    pins[4] = 1'b1; pins[6] = 1'b1; tick();
    check("R6 both pend", status, 32'h50);
    wr(3'd6, 32'h10);
    check("R6 partial", status, 32'h40);
    wr(3'd6, '0);
    check("R6 zeros no effect", status, 32'h40);
    pins[4] = 1'b0; pins[6] = 1'b0; tick();
  endtask

  task automatic t_set_wins();
    setup(32'h10, 32'h10, '0, '0);
    pins[4] = 1'b1; tick();
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'h10; pins[4] = 1'b0;
    tick();
    wr_en = 1'b0;
    check("R7 set wins", status, 32'h10);
  endtask

  task automatic t_lowest();
    setup(32'h220, '0, '0, '0);
    pins[9] = 1'b1; pins[5] = 1'b1; tick(2);
    check("R9 idx 5", N'(low_idx), 5);
    check("R9 valid", N'(low_valid), 1);
    wr(3'd6, 32'h20); tick();
    check("R9 idx 9", N'(low_idx), 9);
    pins[9] = 1'b0; pins[5] = 1'b0; tick();
  endtask

  task automatic t_enable_change();
    setup('0, '0, '0, '0);
    pins[20] = 1'b1; tick(2);
    wr(3'd0, 32'h100000); wr(3'd1, 32'h100000); wr(3'd2, 32'h100000); tick(2);
    check("R10 no spurious", status, '0);
    check("R10 no spurious wake", N'(wake), '0);
    pins[20] = 1'b0; tick();
    check("R10 real edge", status, 32'h100000);
  endtask

  task automatic t_ro_write();
    logic [N-1:0] d;
    setup('0, '0, '0, '0);
    wr(3'd4, '1); wr(3'd5, '1); tick();
    check("R11 status", status, '0);
    rd(3'd5, d); check("R11 wake pend", d, '0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_default_fall();
    t_rise_only();
    t_both();
    t_wake();
    t_clear_partial();
    t_set_wins();
    t_lowest();
    t_enable_change();
    t_ro_write();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule